// File: doc/BRIEF.md
# Index/Data Port Watchdog Timer

This block is a watchdog timer whose registers are reached only through a two-byte window on a byte-wide I/O bus. Software first writes a register number into the index port (offset 0). It then reads or writes the data port (offset 1), and that access goes to the selected register. Inside the window sit a control byte with an enable bit, a byte that chooses where expiry is sent, three bytes forming a 24-bit timeout, and a status byte. The status byte carries a reload strobe and a sticky expiry flag.

A free-running 32768 Hz tick enable comes in as an input. While the timer is enabled, every tick moves the count one step toward expiry. A programmed timeout of N gives an expiry after N+1 ticks, so the longest interval is 2^24 ticks (512 s). On expiry the block reloads itself and sets the sticky flag. It also emits a one-clock request, either a non-maskable interrupt request or a system reset request, depending on the upper nibble of the routing byte. Software keeps the timer quiet by writing the reload strobe before the count runs out.

Top module: `idx_wdt`

## Requirements
- R1: A write to offset 0 stores the index byte, and a read at offset 0 returns it. Every access at offset 1 goes to the internal register named by the stored index.
- R2: Internal registers 0x37 (control), 0x38 (routing), 0x39/0x3A/0x3B (timeout bits 7:0, 15:8, 23:16) read back all 8 written bits. Any index outside 0x37..0x3C reads 0x00 and ignores writes.
- R3: After reset every register is 0x00, the index is 0x00, the timer is disabled and both request outputs are low.
- R4: A 0-to-1 change of control bit 6 (enable) loads the counter from the timeout value N. The first expiry follows the (N+1)-th tick after that load. The counter then reloads by itself, giving one expiry every N+1 ticks.
- R5: While control bit 6 is 0, ticks leave the count unchanged and no expiry happens.
- R6: Writing 1 to bit 6 of register 0x3C restarts the count from N. That bit always reads 0. If this write lands in the same cycle as an expiring tick, the restart wins and no expiry happens.
- R7: Expiry drives a one-clock pulse on nmi_req when the routing upper nibble is 0xC, and on rst_req when it is 0xD. Any other nibble value produces no pulse. The two outputs are never high together.
- R8: Bit 7 of register 0x3C is set by expiry and stays set. Writing 0 to it clears it, and writing 1 leaves it as it is. If expiry and a clearing write fall in the same cycle, the flag ends up set. Bits 5:0 of 0x3C are plain storage.
- R9: Writing the timeout bytes while the timer runs leaves the current count alone. The new value takes effect at the next load, reload or expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock 32768 Hz count enable |
| io_addr | input | 1 | Window offset: 0 index, 1 data |
| io_wr | input | 1 | Write strobe for the addressed port |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data of the addressed port (combinational) |
| nmi_req | output | 1 | One-clock non-maskable interrupt request |
| rst_req | output | 1 | One-clock system reset request |

## Verification
Two pairs of functions can meet in a single clock. One pair is a software restart against the tick that would expire the count. The other is a software clear of the sticky flag against an expiry. The bench steps the count to zero with single ticks, then issues the data-port write with the tick still asserted in that same cycle. It judges the restart case by the absence of any request pulse. It judges the clear case by a pulse together with a flag that reads back as set. A behavioural model, compared every clock, confirms the same outcome cycle by cycle.

// File: rtl/idx_wdt.sv
module idx_wdt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       io_addr,
  input  logic       io_wr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       nmi_req,
  output logic       rst_req
);
  localparam logic [7:0] A_CTRL = 8'h37;
  localparam logic [7:0] A_ROUTE = 8'h38;
  localparam logic [7:0] A_TMO0 = 8'h39;
  localparam logic [7:0] A_TMO1 = 8'h3A;
  localparam logic [7:0] A_TMO2 = 8'h3B;
  localparam logic [7:0] A_STAT = 8'h3C;
  localparam int TMO_W = 24;
  localparam logic [3:0] ROUTE_NMI = 4'hC;
  localparam logic [3:0] ROUTE_RST = 4'hD;

  logic [7:0] idx_q, ctrl_q, route_q;
  logic [5:0] stat_lo_q;
  logic [TMO_W-1:0] tmo_q, cnt_q;
  logic fired_q;

  wire data_wr = io_wr & io_addr;
  wire wr_ctrl = data_wr && (idx_q == A_CTRL);
  wire wr_stat = data_wr && (idx_q == A_STAT);
  wire en_q = ctrl_q[6];
  wire en_rise = wr_ctrl & io_wdata[6] & ~en_q;
  wire reload = wr_stat & io_wdata[6];
  wire load = en_rise | reload;
  wire step = en_q & tick_en & ~load;
  wire expire = step && (cnt_q == '0);
  wire clr_fired = wr_stat & ~io_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ctrl_q <= '0;
      route_q <= '0;
      stat_lo_q <= '0;
      tmo_q <= '0;
    end else begin
      if (io_wr && !io_addr) idx_q <= io_wdata;
      if (data_wr) begin
        case (idx_q)
          A_CTRL:  ctrl_q <= io_wdata;
          A_ROUTE: route_q <= io_wdata;
          A_TMO0:  tmo_q[7:0] <= io_wdata;
          A_TMO1:  tmo_q[15:8] <= io_wdata;
          A_TMO2:  tmo_q[23:16] <= io_wdata;
          A_STAT:  stat_lo_q <= io_wdata[5:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fired_q <= 1'b0;
      nmi_req <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (load || expire) cnt_q <= tmo_q;
      else if (step) cnt_q <= cnt_q - 1'b1;
      if (expire) fired_q <= 1'b1;
      else if (clr_fired) fired_q <= 1'b0;
      nmi_req <= expire && (route_q[7:4] == ROUTE_NMI);
      rst_req <= expire && (route_q[7:4] == ROUTE_RST);
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    if (!io_addr) io_rdata = idx_q;
    else begin
      case (idx_q)
        A_CTRL:  io_rdata = ctrl_q;
        A_ROUTE: io_rdata = route_q;
        A_TMO0:  io_rdata = tmo_q[7:0];
        A_TMO1:  io_rdata = tmo_q[15:8];
        A_TMO2:  io_rdata = tmo_q[23:16];
        A_STAT:  io_rdata = {fired_q, 1'b0, stat_lo_q};
        default: io_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/idx_wdt_chk.sv
module idx_wdt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_addr,
  input logic        io_wr,
  input logic [7:0]  io_wdata,
  input logic        nmi_req,
  input logic        rst_req,
  input logic [7:0]  idx_q,
  input logic [7:0]  ctrl_q,
  input logic [23:0] cnt_q,
  input logic        fired_q,
  input logic        load
);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_req && rst_req));

  a_r8_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req || rst_req) |-> fired_q);

  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[6] && !load) |=> $stable(cnt_q));

  a_r8_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fired_q) |-> $past(io_wr && io_addr && idx_q == 8'h3C && !io_wdata[7]));

  a_r6_reload_blocks_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr && idx_q == 8'h3C && io_wdata[6]) |=> !(nmi_req || rst_req));

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[6]) |=> !(nmi_req || rst_req));
endmodule

bind idx_wdt idx_wdt_chk u_chk (.*);

// File: tb/idx_wdt_test.sv
`timescale 1ns/100ps
module idx_wdt_test;
  logic clk = 0, rst_n = 0, tick_en = 0, io_addr = 0, io_wr = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;
  logic nmi_req, rst_req;
  int checks = 0, failures = 0;
  bit cmp_on = 0;
  int n_nmi = 0, n_rst = 0;

  idx_wdt uut (.*);

  always #2 clk = ~clk;

  int m_idx = 0, m_ctrl = 0, m_route = 0, m_tmo = 0, m_lo = 0, m_fired = 0, m_left = 1;
  bit m_nmi = 0, m_rst = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_ctrl = 0; m_route = 0; m_tmo = 0; m_lo = 0;
      m_fired = 0; m_left = 1; m_nmi = 0; m_rst = 0;
    end else begin
      automatic int old_tmo = m_tmo;
      automatic bit old_en = m_ctrl[6];
      automatic bit ld = 0, clr = 0, fire = 0;
      if (io_wr && !io_addr) m_idx = io_wdata;
      if (io_wr && io_addr) begin
        if (m_idx == 'h37) begin
          if (!old_en && io_wdata[6]) ld = 1;
          m_ctrl = io_wdata;
        end else if (m_idx == 'h38) m_route = io_wdata;
        else if (m_idx == 'h39) m_tmo = (m_tmo & 'hFFFF00) | io_wdata;
        else if (m_idx == 'h3A) m_tmo = (m_tmo & 'hFF00FF) | (io_wdata << 8);
        else if (m_idx == 'h3B) m_tmo = (m_tmo & 'h00FFFF) | (io_wdata << 16);
        else if (m_idx == 'h3C) begin
          m_lo = io_wdata & 'h3F;
          if (io_wdata[6]) ld = 1;
          clr = !io_wdata[7];
        end
      end
      if (ld) m_left = old_tmo + 1;
      else if (old_en && tick_en) begin
        if (m_left == 1) begin fire = 1; m_left = old_tmo + 1; end
        else m_left = m_left - 1;
      end
      if (fire) m_fired = 1; else if (clr) m_fired = 0;
      m_nmi = fire && (m_route / 16 == 'hC);
      m_rst = fire && (m_route / 16 == 'hD);
    end
  end

  function automatic int exp_rdata();
    if (!io_addr) return m_idx;
    case (m_idx)
      'h37: return m_ctrl;
      'h38: return m_route;
      'h39: return m_tmo & 255;
      'h3A: return (m_tmo >> 8) & 255;
      'h3B: return (m_tmo >> 16) & 255;
      'h3C: return m_fired * 128 + m_lo;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk(nmi_req == m_nmi, "R7 nmi_req vs model", nmi_req, m_nmi);
    chk(rst_req == m_rst, "R7 rst_req vs model", rst_req, m_rst);
    chk(io_rdata == exp_rdata(), "R1 io_rdata vs model", io_rdata, exp_rdata());
    if (nmi_req) n_nmi++;
    if (rst_req) n_rst++;
  end

  task automatic wr_io(input bit a, input logic [7:0] d);
    io_addr = a; io_wr = 1; io_wdata = d;
    @(negedge clk); #1;
    io_wr = 0;
  endtask

  task automatic wr_io_tick(input bit a, input logic [7:0] d);
    tick_en = 1;
    wr_io(a, d);
    tick_en = 0;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    wr_io(0, i);
    wr_io(1, d);
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] v);
    wr_io(0, i);
    io_addr = 1;
    @(negedge clk); v = io_rdata; #1;
  endtask

  task automatic pulse_ticks(input int n);
    tick_en = 1;
    repeat (n) @(negedge clk);
    #1 tick_en = 0;
  endtask

  task automatic wait_pulse(output int k);
    tick_en = 1; k = 0;
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (nmi_req || rst_req) begin k = j; break; end
    end
    #1 tick_en = 0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int k, b_nmi, b_rst;
    repeat (3) @(negedge clk);
    #1 rst_n = 1; cmp_on = 1;
    chk(nmi_req == 0 && rst_req == 0, "R3 outputs low after reset", {nmi_req, rst_req}, 0);
    rd_reg(8'h37, v); chk(v == 0, "R3 control reset", v, 0);
    rd_reg(8'h3B, v); chk(v == 0, "R3 timeout reset", v, 0);
    rd_reg(8'h3C, v); chk(v == 0, "R3 status reset", v, 0);

    wr_reg(8'h37, 8'h2B); rd_reg(8'h37, v); chk(v == 8'h2B, "R2 control readback", v, 8'h2B);
    wr_reg(8'h38, 8'h5A); rd_reg(8'h38, v); chk(v == 8'h5A, "R2 routing readback", v, 8'h5A);
    wr_reg(8'h39, 8'h12); wr_reg(8'h3A, 8'h34); wr_reg(8'h3B, 8'h56);
    rd_reg(8'h3A, v); chk(v == 8'h34, "R2 timeout middle byte", v, 8'h34);
    rd_reg(8'h3B, v); chk(v == 8'h56, "R2 timeout upper byte", v, 8'h56);
    wr_reg(8'h3C, 8'h15); rd_reg(8'h3C, v); chk(v == 8'h15, "R8 status low bits stored", v, 8'h15);
    wr_reg(8'h40, 8'hFF); rd_reg(8'h40, v); chk(v == 0, "R2 unimplemented reads zero", v, 0);
    rd_reg(8'h36, v); chk(v == 0, "R2 below range reads zero", v, 0);
    wr_io(0, 8'h3A); io_addr = 0; @(negedge clk); #1;
    chk(io_rdata == 8'h3A, "R1 index port readback", io_rdata, 8'h3A);

    wr_reg(8'h37, 8'h00); wr_reg(8'h38, 8'hC0);
    wr_reg(8'h39, 8'h03); wr_reg(8'h3A, 8'h00); wr_reg(8'h3B, 8'h00);
    wr_reg(8'h3C, 8'h00);
    wr_reg(8'h37, 8'h40);
    wait_pulse(k); chk(k == 4 && nmi_req, "R4 first expiry after N+1 ticks", k, 4);
    wait_pulse(k); chk(k == 4, "R4 periodic expiry", k, 4);
    rd_reg(8'h3C, v); chk(v == 8'h80, "R8 fired flag set", v, 8'h80);
    wr_io(1, 8'h80); rd_reg(8'h3C, v); chk(v == 8'h80, "R8 writing one keeps flag", v, 8'h80);
    wr_io(1, 8'h00); rd_reg(8'h3C, v); chk(v == 8'h00, "R8 writing zero clears", v, 0);
    wr_io(1, 8'h80); rd_reg(8'h3C, v); chk(v == 8'h00, "R8 writing one cannot set", v, 0);

    wr_reg(8'h37, 8'h00); wr_reg(8'h38, 8'hD0); wr_reg(8'h37, 8'h40);
    wait_pulse(k); chk(k == 4 && rst_req && !nmi_req, "R7 reset routing", k, 4);
    wr_reg(8'h38, 8'hE0); wr_reg(8'h3C, 8'h00);
    b_nmi = n_nmi; b_rst = n_rst;
    pulse_ticks(9);
    chk(n_nmi == b_nmi && n_rst == b_rst, "R7 other nibble no pulse", n_nmi + n_rst, b_nmi + b_rst);
    rd_reg(8'h3C, v); chk(v == 8'h80, "R8 flag set without pulse", v, 8'h80);

    wr_reg(8'h37, 8'h00); wr_reg(8'h38, 8'hC0); wr_reg(8'h3C, 8'h00);
    b_nmi = n_nmi;
    pulse_ticks(20);
    chk(n_nmi == b_nmi, "R5 disabled no expiry", n_nmi, b_nmi);
    rd_reg(8'h3C, v); chk(v == 0, "R5 disabled flag stays clear", v, 0);

    wr_reg(8'h39, 8'h09); wr_reg(8'h37, 8'h40);
    pulse_ticks(3);
    wr_reg(8'h39, 8'h00);
    wait_pulse(k); chk(k == 7, "R9 running count unaffected by timeout write", k, 7);
    wait_pulse(k); chk(k == 1, "R9 new timeout after expiry", k, 1);

    wr_reg(8'h37, 8'h00); wr_reg(8'h39, 8'h05); wr_reg(8'h37, 8'h40);
    pulse_ticks(4);
    wr_reg(8'h3C, 8'h40);
    wait_pulse(k); chk(k == 6, "R6 reload restarts count", k, 6);
    rd_reg(8'h3C, v); chk(v == 8'h80, "R6 reload bit reads zero", v, 8'h80);

    wr_reg(8'h37, 8'h00); wr_reg(8'h39, 8'h03); wr_reg(8'h37, 8'h40);
    wr_io(0, 8'h3C);
    pulse_ticks(3);
    b_nmi = n_nmi;
    wr_io_tick(1, 8'h40);
    repeat (2) @(negedge clk); #1;
    chk(n_nmi == b_nmi, "R6 reload beats expiring tick", n_nmi, b_nmi);
    pulse_ticks(3);
    wr_io_tick(1, 8'h00);
    @(negedge clk); #1;
    chk(n_nmi == b_nmi + 1, "R8 expiry during clear pulses", n_nmi, b_nmi + 1);
    io_addr = 1; @(negedge clk);
    chk(io_rdata == 8'h80, "R8 expiry beats clear", io_rdata, 8'h80);

    #1 rst_n = 0; @(negedge clk); #1 rst_n = 1;
    rd_reg(8'h37, v); chk(v == 0, "R3 reset disables timer", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule